// File: doc/BRIEF.md
# Three-field structure interleave load/store unit

This unit moves a group of four three-field records between memory and three 64-bit vector registers in one memory transfer. Memory holds the records back to back: for each record the fields x, y and z sit at rising addresses, then the next record follows. A load reads the whole 24-byte group and sorts it by field. Register 0 then holds x of all four records, register 1 holds y and register 2 holds z. A store takes the three registers and weaves their lanes back into record order before it writes them out.

The unit keeps a base pointer that supplies the address of every transfer. The pointer can be loaded directly while the unit is idle. A command can also ask for write-back, which moves the pointer past the group once the transfer is over. That lets a loop walk an array of records without computing addresses. The command handshake, the memory port and the register port are all single-transfer and in order. Only one command is in flight at any time.

Top module: `aos_ldst_unit`

## Requirements
- R1: After reset the unit is idle: cmd_ready is 1, mem_valid, done and reg_we are 0, and base_ptr is 0.
- R2: On a load, memory element e (the 16-bit field at byte offset 2e, little-endian, bus bits [16e+15:16e]) belongs to record k = e div 3 and field f = e mod 3. It lands in register f (reg_wdata bits [64f+63:64f]) at lane k (bits [16k+15:16k] of that register).
- R3: On a store, register f lane k, taken from reg_rdata in the cycle the command is accepted, goes to memory element 3k+f of mem_wdata. A later change of reg_rdata has no effect on the stored data.
- R4: Each command makes exactly one handshake on the memory port (mem_valid and mem_ready both high). Its address is the base pointer value at acceptance, and mem_write is 1 for a store and 0 for a load.
- R5: While mem_valid is high and mem_ready is low, mem_valid, mem_addr, mem_write and mem_wdata hold steady.
- R6: When cmd_wb was set, base_ptr has grown by 24 in the cycle after done. Without write-back, base_ptr is left unchanged.
- R7: done is high for exactly one cycle. For a store it comes in the cycle after the memory handshake. For a load it comes in the cycle after mem_rvalid. reg_we is high in that same cycle for a load only.
- R8: cmd_ready is low from the cycle after acceptance until done has been seen. A cmd_valid held high during that time starts nothing.
- R9: ptr_set loads ptr_set_val into base_ptr only while the unit is idle. A command accepted in the same cycle still uses the old pointer value. ptr_set has no effect while the unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit idle, command accepted this cycle if valid |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_wb | input | 1 | Advance the base pointer after the transfer |
| ptr_set | input | 1 | Load the base pointer (idle only) |
| ptr_set_val | input | 32 | Value for the base pointer |
| base_ptr | output | 32 | Current base pointer |
| reg_rdata | input | 192 | Three source registers, register f at [64f+63:64f] |
| reg_we | output | 1 | Write the three destination registers |
| reg_wdata | output | 192 | Three destination registers, register f at [64f+63:64f] |
| done | output | 1 | Command finished |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the group |
| mem_wdata | output | 192 | Group written to memory, element e at [16e+15:16e] |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 192 | Group read from memory |

## Verification
A counting pattern, in which every element carries its own index, is loaded and stored. With it, any swap of record and field, or of lanes within a register, shows up as a wrong value at a known bit position. Random data with random write-back choices and random memory delays checks the permutation and the pointer walk against a cycle model. Delayed mem_ready separates a request that is held from one that is dropped or repeated. Changing reg_rdata after acceptance tests that store data is captured at the right moment. A cmd_valid or ptr_set held during a busy transfer tests that such input is ignored.

// File: rtl/aos_pkg.sv
package aos_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_RESP = 2'd2,
      ST_FIN  = 2'd3
   } aos_state_t;

   function automatic int unsigned aos_bus_bits(int unsigned fw, int unsigned lanes,
                                                int unsigned nf);
      return fw * lanes * nf;
   endfunction
endpackage

// File: rtl/aos_lane_unpack.sv
module aos_lane_unpack #(
   parameter int unsigned FIELD_W = 16,
   parameter int unsigned LANES   = 4,
   parameter int unsigned NFIELDS = 3,
   localparam int unsigned XW     = FIELD_W * LANES * NFIELDS
) (
   input  logic [XW-1:0] mem_bus,
   output logic [XW-1:0] reg_bus
);
   for (genvar f = 0; f < NFIELDS; f++) begin : g_field
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign reg_bus[(f*LANES + k)*FIELD_W +: FIELD_W] =
            mem_bus[(k*NFIELDS + f)*FIELD_W +: FIELD_W];
      end
   end
endmodule

// File: rtl/aos_lane_pack.sv
module aos_lane_pack #(
   parameter int unsigned FIELD_W = 16,
   parameter int unsigned LANES   = 4,
   parameter int unsigned NFIELDS = 3,
   localparam int unsigned XW     = FIELD_W * LANES * NFIELDS
) (
   input  logic [XW-1:0] reg_bus,
   output logic [XW-1:0] mem_bus
);
   for (genvar k = 0; k < LANES; k++) begin : g_rec
      for (genvar f = 0; f < NFIELDS; f++) begin : g_fld
         assign mem_bus[(k*NFIELDS + f)*FIELD_W +: FIELD_W] =
            reg_bus[(f*LANES + k)*FIELD_W +: FIELD_W];
      end
   end
endmodule

// File: rtl/aos_base_ptr.sv
module aos_base_ptr #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned STEP   = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [ADDR_W-1:0] set_val,
   input  logic              bump,
   output logic [ADDR_W-1:0] q
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   always_ff @(posedge clk) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= set_val;
      else if (bump)   q <= q + STEP_V;
   end

   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !set_en) |=> (q == $past(q) + STEP_V)); // R6
   AST_PTR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!bump && !set_en) |=> $stable(q)); // R9
endmodule

// File: rtl/aos_ldst_unit.sv
module aos_ldst_unit
   import aos_pkg::*;
#(
   parameter int unsigned FIELD_W = 16,
   parameter int unsigned LANES   = 4,
   parameter int unsigned NFIELDS = 3,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned XW     = FIELD_W * LANES * NFIELDS,
   localparam int unsigned XBYTES = XW / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic              cmd_store,
   input  logic              cmd_wb,
   input  logic              ptr_set,
   input  logic [ADDR_W-1:0] ptr_set_val,
   output logic [ADDR_W-1:0] base_ptr,
   input  logic [XW-1:0]     reg_rdata,
   output logic              reg_we,
   output logic [XW-1:0]     reg_wdata,
   output logic              done,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [XW-1:0]     mem_wdata,
   input  logic              mem_rvalid,
   input  logic [XW-1:0]     mem_rdata
);
   if (FIELD_W % 8 != 0) begin : g_bad_field
      $error("FIELD_W must be a whole number of bytes");
   end
   if (LANES < 1 || NFIELDS < 1) begin : g_bad_shape
      $error("LANES and NFIELDS must be at least 1");
   end
   if (aos_bus_bits(FIELD_W, LANES, NFIELDS) != XW) begin : g_bad_bus
      $error("bus width mismatch");
   end

   aos_state_t        state_q, state_d;
   logic              op_store_q, op_wb_q;
   logic [ADDR_W-1:0] addr_q;
   logic [XW-1:0]     wdata_q, rdata_q;
   logic [XW-1:0]     packed_w, unpacked_w;
   logic              accept;

   assign accept = (state_q == ST_IDLE) && cmd_valid;

   aos_lane_pack #(.FIELD_W(FIELD_W), .LANES(LANES), .NFIELDS(NFIELDS)) u_pack (
      .reg_bus (reg_rdata),
      .mem_bus (packed_w)
   );

   aos_lane_unpack #(.FIELD_W(FIELD_W), .LANES(LANES), .NFIELDS(NFIELDS)) u_unpack (
      .mem_bus (mem_rdata),
      .reg_bus (unpacked_w)
   );

   aos_base_ptr #(.ADDR_W(ADDR_W), .STEP(XBYTES)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (ptr_set && (state_q == ST_IDLE)),
      .set_val (ptr_set_val),
      .bump    ((state_q == ST_FIN) && op_wb_q),
      .q       (base_ptr)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (cmd_valid)  state_d = ST_REQ;
         ST_REQ:  if (mem_ready)  state_d = op_store_q ? ST_FIN : ST_RESP;
         ST_RESP: if (mem_rvalid) state_d = ST_FIN;
         ST_FIN:                  state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         op_store_q <= 1'b0;
         op_wb_q    <= 1'b0;
         addr_q     <= '0;
         wdata_q    <= '0;
         rdata_q    <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            op_store_q <= cmd_store;
            op_wb_q    <= cmd_wb;
            addr_q     <= base_ptr;
            wdata_q    <= packed_w;
         end
         if ((state_q == ST_RESP) && mem_rvalid) rdata_q <= unpacked_w;
      end
   end

   assign cmd_ready = (state_q == ST_IDLE);
   assign mem_valid = (state_q == ST_REQ);
   assign mem_write = op_store_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign done      = (state_q == ST_FIN);
   assign reg_we    = (state_q == ST_FIN) && !op_store_q;
   assign reg_wdata = rdata_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (done && !mem_write)); // R7
   AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid || done) |-> !cmd_ready); // R8
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                     && $stable(mem_wdata) && $stable(mem_write))); // R5
   AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |=> !mem_valid); // R4
   AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && cmd_valid) |=> (mem_valid && mem_addr == $past(base_ptr))); // R4
endmodule

// File: tb/aos_ldst_unit_bench.sv
module aos_ldst_unit_bench;
   localparam int XW = 192;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_store = 1'b0, cmd_wb = 1'b0;
   logic          ptr_set = 1'b0;
   logic [AW-1:0] ptr_set_val = '0;
   logic [XW-1:0] reg_rdata = '0, mem_rdata = '0;
   logic          mem_ready = 1'b0, mem_rvalid = 1'b0;
   logic          cmd_ready, reg_we, done, mem_valid, mem_write;
   logic [AW-1:0] base_ptr, mem_addr;
   logic [XW-1:0] reg_wdata, mem_wdata;

   always #4 clk = ~clk;

   aos_ldst_unit u_aos_ldst_unit (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_store(cmd_store), .cmd_wb(cmd_wb), .ptr_set(ptr_set),
      .ptr_set_val(ptr_set_val), .base_ptr(base_ptr), .reg_rdata(reg_rdata),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .done(done), .mem_valid(mem_valid),
      .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   task automatic chk(input logic [XW-1:0] act, input logic [XW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [XW-1:0] to_mem(input logic [XW-1:0] r);
      logic [XW-1:0] m = '0;
      for (int s = 0; s < 4; s++)
         for (int f = 0; f < 3; f++)
            m[(3*s+f)*16 +: 16] = r[(4*f+s)*16 +: 16];
      return m;
   endfunction

   function automatic logic [XW-1:0] to_regs(input logic [XW-1:0] m);
      logic [XW-1:0] r = '0;
      for (int e = 0; e < 12; e++)
         r[(4*(e%3) + e/3)*16 +: 16] = m[e*16 +: 16];
      return r;
   endfunction

   // behavioural reference: phase 0 idle, 1 request, 2 wait data, 3 finish
   int            m_phase = 0;
   bit            m_store, m_wb;
   logic [AW-1:0] m_ptr = '0, m_addr = '0;
   logic [XW-1:0] m_wdata = '0, m_regs = '0, last_store = '0;
   int            xfers = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_ptr = '0; m_regs = '0; xfers = 0;
      end else begin
         case (m_phase)
            0: begin
               if (cmd_valid) begin
                  m_store = cmd_store; m_wb = cmd_wb; m_addr = m_ptr;
                  m_wdata = to_mem(reg_rdata); m_phase = 1;
               end
               if (ptr_set) m_ptr = ptr_set_val;
            end
            1: if (mem_ready) begin
               xfers++;
               if (m_store) last_store = mem_wdata;
               m_phase = m_store ? 3 : 2;
            end
            2: if (mem_rvalid) begin
               m_regs = to_regs(mem_rdata); m_phase = 3;
            end
            default: begin
               if (m_wb) m_ptr = m_ptr + 32'd24;
               m_phase = 0;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(XW'(cmd_ready), XW'(m_phase == 0), "R8 cmd_ready");
         chk(XW'(mem_valid), XW'(m_phase == 1), "R4 mem_valid");
         chk(XW'(done), XW'(m_phase == 3), "R7 done");
         chk(XW'(reg_we), XW'(m_phase == 3 && !m_store), "R7 reg_we");
         chk(XW'(base_ptr), XW'(m_ptr), "R6 base_ptr");
         if (mem_valid) begin
            chk(XW'(mem_addr), XW'(m_addr), "R4 mem_addr");
            chk(XW'(mem_write), XW'(m_store), "R4 mem_write");
            if (m_store) chk(mem_wdata, m_wdata, "R3 mem_wdata");
         end
         if (reg_we) chk(reg_wdata, m_regs, "R2 reg_wdata");
      end
   end

   // one command; ready/response delays in cycles
   task automatic run_cmd(input bit st, input bit wb, input int rdy_dly, input int rsp_dly,
                          input logic [XW-1:0] regs, input logic [XW-1:0] memd,
                          input bit hold_valid, input bit poke_ptr);
      @(negedge clk);
      cmd_valid = 1; cmd_store = st; cmd_wb = wb; reg_rdata = regs;
      @(negedge clk);
      if (!hold_valid) cmd_valid = 0;
      reg_rdata = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (poke_ptr) begin ptr_set = 1; ptr_set_val = 32'hDEAD0000; end
      for (int i = 0; i < rdy_dly; i++) begin
         @(negedge clk);
         ptr_set = 0;
      end
      mem_ready = 1;
      @(negedge clk);
      mem_ready = 0; ptr_set = 0;
      if (!st) begin
         for (int i = 0; i < rsp_dly; i++) begin
            mem_rdata = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            @(negedge clk);
         end
         mem_rvalid = 1; mem_rdata = memd;
         @(negedge clk);
         mem_rvalid = 0;
      end
      cmd_valid = 0;
      @(negedge clk);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            finish_run();
         end
      end
   end

   initial begin
      logic [XW-1:0] cnt_mem, cnt_regs;
      int x0;
      for (int e = 0; e < 12; e++) cnt_mem[e*16 +: 16] = 16'hA000 + 16'(e);
      for (int f = 0; f < 3; f++)
         for (int k = 0; k < 4; k++)
            cnt_regs[(4*f+k)*16 +: 16] = {4'hC, 4'(f), 4'(k), 4'h0};

      repeat (3) @(negedge clk);
      chk(XW'({cmd_ready, mem_valid, done, reg_we}), XW'(4'b1000), "R1 idle outputs");
      chk(XW'(base_ptr), '0, "R1 base_ptr");
      rst_n = 1;
      @(negedge clk);
      ptr_set = 1; ptr_set_val = 32'h1000;
      @(negedge clk);
      ptr_set = 0;
      chk(XW'(base_ptr), XW'(32'h1000), "R9 ptr_set idle");

      // counting load with write-back
      run_cmd(0, 1, 0, 2, '0, cnt_mem, 0, 0);
      chk(XW'(reg_wdata[15:0]),    XW'(16'hA000), "R2 reg0 lane0");
      chk(XW'(reg_wdata[31:16]),   XW'(16'hA003), "R2 reg0 lane1");
      chk(XW'(reg_wdata[79:64]),   XW'(16'hA001), "R2 reg1 lane0");
      chk(XW'(reg_wdata[191:176]), XW'(16'hA00B), "R2 reg2 lane3");
      chk(XW'(base_ptr), XW'(32'h1018), "R6 step 24");

      // counting store, no write-back, slow memory
      run_cmd(1, 0, 3, 0, cnt_regs, '0, 0, 0);
      chk(XW'(last_store[47:32]),   XW'(16'hC200), "R3 element 2");
      chk(XW'(last_store[79:64]),   XW'(16'hC110), "R3 element 4");
      chk(XW'(last_store[191:176]), XW'(16'hC230), "R3 element 11");
      chk(XW'(base_ptr), XW'(32'h1018), "R6 no write-back");
      chk(XW'(xfers), XW'(2), "R4 one transfer each");

      // cmd_valid held and ptr_set poked while busy
      run_cmd(0, 0, 2, 1, '1, {96'h0, {6{16'h5A5A}}}, 1, 1);
      chk(XW'(base_ptr), XW'(32'h1018), "R9 ptr_set busy ignored");
      chk(XW'(xfers), XW'(3), "R8 held valid no restart");

      // random mix
      for (int n = 0; n < 40; n++) begin
         logic [XW-1:0] a, b;
         a = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
         b = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
         run_cmd(1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 4),
                 a, b, 0, 0);
      end
      x0 = xfers;
      chk(XW'(x0), XW'(43), "R4 transfer count");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule